// File: doc/BRIEF.md
# Branch Target Buffer with Next-Fetch Address Select

This block supplies the fetch stage with its next fetch address. A small direct-mapped table holds, for each slot, a valid flag, the upper address bits of the branch that owns the slot, and that branch's target. The fetch address is looked up in the same cycle as the external direction predictor. The block reports whether the lookup hit and which target is stored. It then picks the next fetch address: the stored target when the lookup hits and the predictor says taken, otherwise the sequential address.

The execute stage writes through a single port. Every resolved branch installs or overwrites its slot with the computed target, whether the branch was taken or not, so that the target is on hand the next time the predictor says taken. A target that proved wrong is fixed by the same kind of write. The write is registered, so a lookup in the same cycle still sees the old slot contents.

Top module: `btb_nextpc`

## Requirements
- R1: After reset every slot is invalid: any lookup reports `fe_hit`=0 and `fe_next_pc`=`fe_pc`+4.
- R2: The slot is chosen by address bits [IDX_W+1:2] (bits [5:2] with 16 slots). The tag is bits [ADDR_W-1:IDX_W+2]. Bits [1:0] take no part in the match. A hit requires a set valid flag and an equal tag.
- R3: On a hit with `fe_taken_pred`=1, `fe_next_pc` equals the stored target.
- R4: On a hit with `fe_taken_pred`=0, `fe_next_pc` is `fe_pc`+4, while `fe_target` still shows the stored target.
- R5: On a miss, `fe_next_pc` is `fe_pc`+4 whatever `fe_taken_pred` is.
- R6: A cycle with `ex_wr_valid`=0 changes no slot, whatever `ex_wr_pc` and `ex_wr_target` carry.
- R7: A write with `ex_wr_valid`=1 makes the slot of `ex_wr_pc` valid, with that tag and `ex_wr_target`, from the next cycle on.
- R8: A lookup in the same cycle as a write to the same slot returns the slot's contents from before the write.
- R9: A write replaces the slot's earlier contents: a new target for the same branch, or a different branch that maps to the same slot, which evicts the old one.
- R10: The sequential address wraps modulo 2^ADDR_W (0xFFFFFFFC gives 0x00000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_pc | input | ADDR_W | Fetch address being looked up |
| fe_taken_pred | input | 1 | Direction prediction for this fetch (1 = taken) |
| fe_hit | output | 1 | Lookup found a valid slot with matching tag |
| fe_target | output | ADDR_W | Target stored in the selected slot |
| fe_next_pc | output | ADDR_W | Chosen next fetch address |
| ex_wr_valid | input | 1 | Execute has a resolved branch to record |
| ex_wr_pc | input | ADDR_W | Address of the resolved branch |
| ex_wr_target | input | ADDR_W | Computed target of the resolved branch |

## Verification
The bench builds the block with its default values: 32-bit addresses and 16 slots (IDX_W=4). With these values, two addresses 64 bytes apart alias to one slot, so eviction and tag mismatch on a shared slot can be reached with ordinary addresses. The top of the address space is reachable, so the wrap of the sequential address can be checked. Writes and lookups to the same slot in the same cycle are driven to show that the write lands only at the clock edge.

// File: rtl/btb_pkg.sv
package btb_pkg;
    // Instructions are word aligned; the low address bits never index or tag.
    localparam int ALIGN_W  = 2;
    localparam int SEQ_STEP = 4;

    typedef enum logic [0:0] {
        NPC_SEQ    = 1'b0,
        NPC_TARGET = 1'b1
    } npc_src_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0]                          addr,
    output logic [IDX_W-1:0]                           idx,
    output logic [ADDR_W-IDX_W-btb_pkg::ALIGN_W-1:0]   tag
);
    localparam int LO = btb_pkg::ALIGN_W;

    always_comb begin
        idx = addr[LO +: IDX_W];
        tag = addr[ADDR_W-1:LO+IDX_W];
    end
endmodule

// File: rtl/btb_store.sv
module btb_store #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [IDX_W-1:0]                           rd_idx,
    output logic                                       rd_valid,
    output logic [ADDR_W-IDX_W-btb_pkg::ALIGN_W-1:0]   rd_tag,
    output logic [ADDR_W-1:0]                          rd_target,
    input  logic                                       wr_en,
    input  logic [IDX_W-1:0]                           wr_idx,
    input  logic [ADDR_W-IDX_W-btb_pkg::ALIGN_W-1:0]   wr_tag,
    input  logic [ADDR_W-1:0]                          wr_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W - btb_pkg::ALIGN_W;

    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q    [DEPTH];
    logic [ADDR_W-1:0] target_q [DEPTH];

    // Only the valid flags need a reset; payload is qualified by them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            target_q[wr_idx] <= wr_target;
        end
    end

    // Read is combinational from the registers, so a same-cycle write is
    // not yet visible.
    always_comb begin
        rd_valid  = valid_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_target = target_q[rd_idx];
    end
endmodule

// File: rtl/btb_npc_select.sv
module btb_npc_select #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic               hit,
    input  logic               taken_pred,
    input  logic [ADDR_W-1:0]  target,
    output btb_pkg::npc_src_e  src,
    output logic [ADDR_W-1:0]  next_pc
);
    import btb_pkg::*;

    logic [ADDR_W-1:0] seq_pc;

    always_comb begin
        seq_pc = pc + ADDR_W'(SEQ_STEP);
        src    = (hit && taken_pred) ? NPC_TARGET : NPC_SEQ;
        unique case (src)
            NPC_TARGET: next_pc = target;
            NPC_SEQ:    next_pc = seq_pc;
            default:    next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/btb_nextpc.sv
module btb_nextpc #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fe_pc,
    input  logic              fe_taken_pred,
    output logic              fe_hit,
    output logic [ADDR_W-1:0] fe_target,
    output logic [ADDR_W-1:0] fe_next_pc,
    input  logic              ex_wr_valid,
    input  logic [ADDR_W-1:0] ex_wr_pc,
    input  logic [ADDR_W-1:0] ex_wr_target
);
    localparam int TAG_W = ADDR_W - IDX_W - btb_pkg::ALIGN_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_target;
    logic              wr_en;
    btb_pkg::npc_src_e npc_src;

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_split (
        .addr (fe_pc),
        .idx  (lk_idx),
        .tag  (lk_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr_split (
        .addr (ex_wr_pc),
        .idx  (wr_idx),
        .tag  (wr_tag)
    );

    // An unknown or low qualifier never writes.
    assign wr_en = (ex_wr_valid == 1'b1);

    btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_target (ex_wr_target)
    );

    assign fe_hit    = rd_valid && (rd_tag == lk_tag);
    assign fe_target = rd_target;

    btb_npc_select #(.ADDR_W(ADDR_W)) u_select (
        .pc         (fe_pc),
        .hit        (fe_hit),
        .taken_pred (fe_taken_pred),
        .target     (rd_target),
        .src        (npc_src),
        .next_pc    (fe_next_pc)
    );
endmodule

// File: rtl/btb_nextpc_chk.sv
module btb_nextpc_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fe_pc,
    input logic              fe_taken_pred,
    input logic              fe_hit,
    input logic [ADDR_W-1:0] fe_target,
    input logic [ADDR_W-1:0] fe_next_pc,
    input logic              ex_wr_valid,
    input logic [ADDR_W-1:0] ex_wr_pc,
    input logic [ADDR_W-1:0] ex_wr_target
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> !fe_hit);

    assert_taken_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_hit && fe_taken_pred) |-> (fe_next_pc == fe_target));

    assert_seq_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_hit && fe_taken_pred) |-> (fe_next_pc == fe_pc + ADDR_W'(4)));

    assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!ex_wr_valid) && $stable(fe_pc))
            |-> ($stable(fe_hit) && (!fe_hit || $stable(fe_target))));

    assert_install_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wr_valid == 1'b1)
            |=> ((fe_pc != $past(ex_wr_pc))
                 || (fe_hit && fe_target == $past(ex_wr_target))));
endmodule

bind btb_nextpc btb_nextpc_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/btb_nextpc_bench.sv
module btb_nextpc_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fe_pc;
    logic        fe_taken_pred;
    logic        fe_hit;
    logic [31:0] fe_target;
    logic [31:0] fe_next_pc;
    logic        ex_wr_valid;
    logic [31:0] ex_wr_pc;
    logic [31:0] ex_wr_target;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    btb_nextpc #(.ADDR_W(32), .IDX_W(4)) u_btb_nextpc (
        .clk           (clk),
        .rst_n         (rst_n),
        .fe_pc         (fe_pc),
        .fe_taken_pred (fe_taken_pred),
        .fe_hit        (fe_hit),
        .fe_target     (fe_target),
        .fe_next_pc    (fe_next_pc),
        .ex_wr_valid   (ex_wr_valid),
        .ex_wr_pc      (ex_wr_pc),
        .ex_wr_target  (ex_wr_target)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then let the lookup settle.
    task automatic cyc(logic [31:0] pc, logic tk, logic wv,
                       logic [31:0] wpc, logic [31:0] wt);
        @(negedge clk);
        fe_pc = pc; fe_taken_pred = tk;
        ex_wr_valid = wv; ex_wr_pc = wpc; ex_wr_target = wt;
        #2;
    endtask

    task automatic look(logic [31:0] pc, logic tk);
        cyc(pc, tk, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_reset;
        look(32'h0000_1000, 1'b1);
        chk("R1 hit", {31'b0, fe_hit}, 32'd0);
        chk("R1 next", fe_next_pc, 32'h0000_1004);
        look(32'h0000_203C, 1'b0);
        chk("R1 hit idx15", {31'b0, fe_hit}, 32'd0);
    endtask

    task automatic t_install;
        cyc(32'h0000_1010, 1'b0, 1'b1, 32'h0000_1010, 32'h0000_0800);
        look(32'h0000_1010, 1'b1);
        chk("R7 hit", {31'b0, fe_hit}, 32'd1);
        chk("R3 next", fe_next_pc, 32'h0000_0800);
        look(32'h0000_1010, 1'b0);
        chk("R4 next", fe_next_pc, 32'h0000_1014);
        chk("R4 target", fe_target, 32'h0000_0800);
        look(32'h0000_1012, 1'b1);
        chk("R2 low bits ignored", {31'b0, fe_hit}, 32'd1);
    endtask

    task automatic t_tag_miss;
        look(32'h0000_2010, 1'b1); // same slot 4, other tag
        chk("R2 tag miss", {31'b0, fe_hit}, 32'd0);
        chk("R5 next", fe_next_pc, 32'h0000_2014);
        look(32'h0000_1014, 1'b1); // same tag, slot 5 empty
        chk("R2 index miss", {31'b0, fe_hit}, 32'd0);
    endtask

    task automatic t_ignored;
        cyc(32'h0000_3020, 1'b0, 1'b0, 32'h0000_3020, 32'h0000_4444);
        cyc(32'h0000_1010, 1'b1, 1'b0, 32'h0000_1010, 32'h0000_9999);
        look(32'h0000_3020, 1'b1);
        chk("R6 no install", {31'b0, fe_hit}, 32'd0);
        look(32'h0000_1010, 1'b1);
        chk("R6 no overwrite", fe_next_pc, 32'h0000_0800);
    endtask

    task automatic t_same_cycle;
        cyc(32'h0000_1010, 1'b1, 1'b1, 32'h0000_1010, 32'h0000_0C00);
        chk("R8 old target", fe_next_pc, 32'h0000_0800);
        look(32'h0000_1010, 1'b1);
        chk("R9 new target", fe_next_pc, 32'h0000_0C00);
        cyc(32'h0000_3020, 1'b1, 1'b1, 32'h0000_3020, 32'h0000_5000);
        chk("R8 old invalid", {31'b0, fe_hit}, 32'd0);
    endtask

    task automatic t_evict;
        cyc(32'h0000_5010, 1'b0, 1'b1, 32'h0000_5010, 32'h0000_6000);
        look(32'h0000_1010, 1'b1);
        chk("R9 evicted", {31'b0, fe_hit}, 32'd0);
        chk("R9 evicted next", fe_next_pc, 32'h0000_1014);
        look(32'h0000_5010, 1'b1);
        chk("R9 new owner", fe_next_pc, 32'h0000_6000);
    endtask

    task automatic t_wrap;
        look(32'hFFFF_FFFC, 1'b1);
        chk("R10 wrap", fe_next_pc, 32'h0000_0000);
    endtask

    initial begin
        rst_n = 1'b0; fe_pc = '0; fe_taken_pred = 1'b0;
        ex_wr_valid = 1'b0; ex_wr_pc = '0; ex_wr_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_install();
        t_tag_miss();
        t_ignored();
        t_same_cycle();
        t_evict();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule